// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for an 8-bit successive-approximation analog-to-digital converter that serves eight multiplexed analog inputs. A one-cycle start request, accompanied by a channel number, begins a conversion. The block then holds the selected channel and the sample-and-hold enable for a fixed sampling window. After that it runs one trial per result bit, from the most significant bit down. In each trial it drives a candidate code to an external DAC and reads back a single comparator bit that reports whether the held input is at or above that code.

All timing is counted in conversion-clock periods. A control bit, captured at start, sets the conversion clock to either the system clock or half of it. One conversion always takes the same number of conversion-clock periods. The cycles left over after the sampling window are divided as evenly as possible among the bit trials, and the spare cycles go to the higher bits. When the last bit is resolved, the result register loads, the busy flag drops, and a one-cycle done pulse fires, which can serve as an interrupt.

The comparator, DAC and sample-and-hold sit outside the block. The host sees the busy flag, the done pulse and the result.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, busy, sampleEn and donePulse are 0, and result, dacCode and chanSel are all zero.
- R2: A start accepted while idle copies chanReq into chanSel. chanSel keeps that value until the next accepted start, whatever chanReq does in the meantime.
- R3: sampleEn rises in the cycle after an accepted start. It stays high for exactly 12 conversion-clock periods: 12 system cycles with clkHalf=0, or 24 with clkHalf=1.
- R4: busy stays high for exactly 160 conversion-clock periods: 160 system cycles with clkHalf=0, or 320 with clkHalf=1. clkHalf is sampled only when a start is accepted.
- R5: Bits are resolved most significant first. The first trial code after sampling is 0x80. Each trial sets its bit; the bit is kept if compIn is 1 at the end of its slot and cleared if compIn is 0.
- R6: The 148 periods after sampling are split across the 8 bit slots. Bits 7 to 4 get 19 periods each and bits 3 to 0 get 18 each. The bit-7 decision therefore takes effect at conversion-clock period 31 after start.
- R7: donePulse is high for exactly one system cycle, in the cycle where busy first reads 0. result loads at the same edge and holds until the next done pulse.
- R8: A start request while busy is ignored. The running conversion's length, channel and result are unchanged.
- R9: With an ideal comparator (compIn = input >= dacCode), an input of 0 yields 0x00, full scale (255) yields 0xFF, and any input level v yields v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start request, acted on only when idle |
| chanReq | input | 3 | Channel number captured at start |
| clkHalf | input | 1 | 0: conversion clock = system clock; 1: system clock / 2 |
| compIn | input | 1 | Comparator: 1 when the held input >= dacCode |
| busy | output | 1 | Conversion in progress |
| sampleEn | output | 1 | Sample-and-hold tracking window |
| chanSel | output | 3 | Latched channel driving the input multiplexer |
| dacCode | output | 8 | Current trial code to the DAC |
| result | output | 8 | Last completed conversion result |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
Random input levels on random channels, at both clock rates, show that the result tracks the selected channel's level rather than another channel's. Because chanReq is scrambled during each conversion, a mux that follows the live request instead of the latched channel would produce wrong results. Directed levels 0x00, 0xFF, 0x7F and 0x80 test the two ends of the range and the MSB decision boundary. The trial code is sampled on each side of the bit-7 decision edge, which confirms both MSB-first ordering and the uneven slot split. A start issued in the middle of a conversion, with a different channel, confirms that such a request cannot lengthen the conversion, restart it or redirect it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic clearTrial;
    logic setBit;
    logic decideBit;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS     = 8,
  parameter int NUM_CH       = 8,
  parameter int SAMPLE_TICKS = 12,
  parameter int TOTAL_TICKS  = 160,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IDX_W = $clog2(RES_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CH_W-1:0]  chanReq,
  input  logic             clkHalf,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] setIdx,
  output logic [IDX_W-1:0] decideIdx,
  output logic             busy,
  output logic             sampleEn,
  output logic [CH_W-1:0]  chanSel,
  output logic             donePulse
);

  localparam int TRIAL_TICKS = TOTAL_TICKS - SAMPLE_TICKS;
  localparam int SLOT_BASE   = TRIAL_TICKS / RES_BITS;
  localparam int SLOT_EXTRA  = TRIAL_TICKS % RES_BITS;
  localparam int CNT_W       = $clog2(TOTAL_TICKS + 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_TICKS - 1);
  localparam logic [CNT_W-1:0] SLOT_LONG   = CNT_W'(SLOT_BASE);
  localparam logic [CNT_W-1:0] SLOT_SHORT  = CNT_W'(SLOT_BASE - 1);
  localparam logic [IDX_W-1:0] MSB_IDX     = IDX_W'(RES_BITS - 1);
  localparam logic [IDX_W-1:0] LONG_FLOOR  = IDX_W'(RES_BITS - SLOT_EXTRA);

  seqState_t        state;
  logic             halfRate;
  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tickTotal;
  logic [IDX_W-1:0] bitIdx;
  logic [CH_W-1:0]  chanReg;
  logic             doneReg;

  logic             tick;
  logic             startOk;
  logic [CNT_W-1:0] slotLast;
  logic             phaseEnd;

  assign startOk  = (state == ST_IDLE) && startReq;
  assign tick     = (state != ST_IDLE) && (!halfRate || phase);
  // Leftover periods go to the most significant slots
  assign slotLast = (SLOT_EXTRA > 0 && bitIdx >= LONG_FLOOR) ? SLOT_LONG : SLOT_SHORT;
  assign phaseEnd = tick && (cnt == ((state == ST_SAMPLE) ? SAMPLE_LAST : slotLast));

  always_comb begin
    strobe            = '0;
    strobe.clearTrial = startOk;
    strobe.decideBit  = phaseEnd && (state == ST_TRIAL);
    strobe.commit     = strobe.decideBit && (bitIdx == '0);
    strobe.setBit     = phaseEnd && ((state == ST_SAMPLE) || (bitIdx != '0));
    setIdx            = (state == ST_SAMPLE) ? MSB_IDX : bitIdx - 1'b1;
    decideIdx         = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfRate  <= 1'b0;
      phase     <= 1'b0;
      cnt       <= '0;
      tickTotal <= '0;
      bitIdx    <= '0;
      chanReg   <= '0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (startOk) begin
        state     <= ST_SAMPLE;
        halfRate  <= clkHalf;
        phase     <= 1'b0;
        cnt       <= '0;
        tickTotal <= '0;
        chanReg   <= chanReq;
      end else if (state != ST_IDLE) begin
        phase <= ~phase;
        if (tick) begin
          tickTotal <= tickTotal + 1'b1;
          cnt       <= phaseEnd ? '0 : cnt + 1'b1;
        end
        if (phaseEnd) begin
          if (state == ST_SAMPLE) begin
            state  <= ST_TRIAL;
            bitIdx <= MSB_IDX;
          end else if (bitIdx == '0) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sampleEn  = (state == ST_SAMPLE);
  assign chanSel   = chanReg;
  assign donePulse = doneReg;

  p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startOk) |=> $stable(chanSel));
  p_sample_inside_r3: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> busy);
  p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (tickTotal < CNT_W'(TOTAL_TICKS)));
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !strobe.commit) |=> busy);

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 8,
  localparam int IDX_W = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [IDX_W-1:0]    setIdx,
  input  logic [IDX_W-1:0]    decideIdx,
  input  logic                compIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] result
);

  logic [RES_BITS-1:0] trial;
  logic [RES_BITS-1:0] trialNext;

  always_comb begin
    trialNext = trial;
    if (strobe.clearTrial)
      trialNext = '0;
    if (strobe.decideBit && !compIn)
      trialNext[decideIdx] = 1'b0;
    if (strobe.setBit)
      trialNext[setIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trial  <= '0;
      result <= '0;
    end else begin
      trial <= trialNext;
      if (strobe.commit)
        result <= trialNext;
    end
  end

  assign dacCode = trial;

  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setBit && strobe.decideBit) |-> (setIdx < decideIdx));
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(result));
  p_commit_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> !strobe.setBit);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS     = 8,
  parameter int NUM_CH       = 8,
  parameter int SAMPLE_TICKS = 12,
  parameter int TOTAL_TICKS  = 160
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startReq,
  input  logic [$clog2(NUM_CH)-1:0] chanReq,
  input  logic                      clkHalf,
  input  logic                      compIn,
  output logic                      busy,
  output logic                      sampleEn,
  output logic [$clog2(NUM_CH)-1:0] chanSel,
  output logic [RES_BITS-1:0]       dacCode,
  output logic [RES_BITS-1:0]       result,
  output logic                      donePulse
);

  localparam int IDX_W = $clog2(RES_BITS);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] setIdx;
  logic [IDX_W-1:0] decideIdx;

  sar_seq_ctrl #(
    .RES_BITS(RES_BITS), .NUM_CH(NUM_CH),
    .SAMPLE_TICKS(SAMPLE_TICKS), .TOTAL_TICKS(TOTAL_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanReq(chanReq),
    .clkHalf(clkHalf), .strobe(strobe), .setIdx(setIdx),
    .decideIdx(decideIdx), .busy(busy), .sampleEn(sampleEn),
    .chanSel(chanSel), .donePulse(donePulse)
  );

  sar_seq_dp #(.RES_BITS(RES_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setIdx(setIdx),
    .decideIdx(decideIdx), .compIn(compIn), .dacCode(dacCode),
    .result(result)
  );

endmodule

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [2:0] chanReq = '0;
  logic       clkHalf = 1'b0;
  logic       compIn;
  logic       busy, sampleEn, donePulse;
  logic [2:0] chanSel;
  logic [7:0] dacCode, result;

  logic [7:0] analogVal [8];
  int testCount = 0;
  int failCount = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  // Ideal comparator: selected input against DAC code
  assign compIn = (analogVal[chanSel] >= dacCode);

  sar_seq_top dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanReq(chanReq),
    .clkHalf(clkHalf), .compIn(compIn), .busy(busy), .sampleEn(sampleEn),
    .chanSel(chanSel), .dacCode(dacCode), .result(result),
    .donePulse(donePulse)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCount + 1, failCount);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expTrialAfterMsb(input logic [7:0] v);
    return (v >= 8'h80) ? 8'hC0 : 8'h40;
  endfunction

  task automatic runConv(input logic [2:0] ch, input logic half, input logic intrude);
    int mult = half ? 2 : 1;
    int busyCnt = 0;
    int sampCnt = 0;
    int k = 0;
    logic chanOk = 1'b1;
    logic [7:0] expRes = analogVal[ch];
    @(negedge clk);
    startReq = 1'b1; chanReq = ch; clkHalf = half;
    @(negedge clk);
    startReq = 1'b0;
    while (busy) begin
      k++;
      busyCnt++;
      if (sampleEn) sampCnt++;
      if (chanSel != ch) chanOk = 1'b0;
      chanReq = 3'($urandom);
      clkHalf = 1'($urandom);
      if (k == 1) chk(sampleEn == 1'b1, "R3 sampleEn rises after start", int'(sampleEn), 1);
      if (k == 31 * mult) chk(dacCode == 8'h80, "R5/R6 MSB trial code before decision", dacCode, 8'h80);
      if (k == 31 * mult + 1)
        chk(dacCode == expTrialAfterMsb(expRes), "R5/R6 code after MSB decision",
            dacCode, expTrialAfterMsb(expRes));
      if (intrude && k == 60) begin
        startReq = 1'b1; chanReq = ch + 3'd1;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
      if (k > 400) break;
    end
    chk(chanOk, "R2 chanSel latched", int'(chanSel), int'(ch));
    chk(sampCnt == 12 * mult, "R3 sample window length", sampCnt, 12 * mult);
    chk(busyCnt == 160 * mult, intrude ? "R8 busy length with intruding start" : "R4 busy length",
        busyCnt, 160 * mult);
    chk(donePulse == 1'b1, "R7 done when busy drops", int'(donePulse), 1);
    chk(result == expRes, intrude ? "R8 result unchanged by intruding start" : "R9 result value",
        result, expRes);
    @(negedge clk);
    chk(donePulse == 1'b0, "R7 done lasts one cycle", int'(donePulse), 0);
    chk(result == expRes, "R7 result held", result, expRes);
    chk(busy == 1'b0, "R8 no restart after intrude", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'h5A3C_0F17));
    for (int i = 0; i < 8; i++) analogVal[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(busy == 0 && sampleEn == 0 && donePulse == 0, "R1 reset flags", int'(busy), 0);
    chk(result == 0 && dacCode == 0 && chanSel == 0, "R1 reset values", result, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    analogVal[3] = 8'h00; runConv(3'd3, 1'b0, 1'b0);   // R9 zero
    analogVal[5] = 8'hFF; runConv(3'd5, 1'b1, 1'b0);   // R9 full scale
    analogVal[0] = 8'h7F; runConv(3'd0, 1'b0, 1'b0);   // R5 MSB boundary
    analogVal[7] = 8'h80; runConv(3'd7, 1'b1, 1'b0);   // R5 MSB boundary
    analogVal[2] = 8'hA5; runConv(3'd2, 1'b0, 1'b1);   // R8 intruding start
    analogVal[6] = 8'h3C; runConv(3'd6, 1'b1, 1'b1);   // R8 at half rate

    // Random conversions
    for (int n = 0; n < 30; n++) begin
      for (int i = 0; i < 8; i++) analogVal[i] = 8'($urandom);
      runConv(3'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule